// File: doc/BRIEF.md
# I2C SCL Divider and Edge-Delay Generator

This block turns a fast core clock into the SCL waveform of an I2C master and marks two instants for the bit shifter that sits beside it. The first is the point after each SCL falling edge where the next SDA bit should be put on the wire. The second is the point after each SCL rising edge where SDA should be read. The byte sequencer, start and stop generation, and SDA itself are handled elsewhere. This block only provides the clock level and two single-cycle strobes.

The divider input is always treated as even, because its least significant bit is dropped. SCL spends half of the even divider value in core clocks high and the other half low. The delay input packs two counts. The upper half is the drive delay, measured from the falling edge. The lower half is the sample delay, measured from the rising edge. Each delay is limited to the length of one SCL phase.

All inputs are plain control levels. There is no streaming data path and no handshake. While `enable` is low, SCL rests high and no strobe is produced.

Top module: `i2c_scl_timing`

## Requirements
- R1: While reset is asserted, or after any clock edge at which `enable` was low, `scl_out` is 1 and the phase counter is at its start. Both strobes are 0 while reset is asserted or while `enable` is low.
- R2: The phase length H is `div_value` shifted right by one bit. Once enabled, SCL stays high for H core clocks and then alternates between H clocks low and H clocks high, so the period is 2*H clocks.
- R3: Bit 0 of `div_value` has no effect. An odd value produces exactly the same waveform and strobes as that value minus one.
- R4: A `div_value` of 0 or 1 behaves like 2, giving H = 1, so SCL toggles on every enabled core clock.
- R5: Let D be `delay_word[31:16]`, the drive delay. `drive_stb` is 1 during the core clock that comes D clocks after SCL went low, counting the first low clock as 0. It is never 1 while SCL is high.
- R6: Let D be `delay_word[15:0]`, the sample delay. `sample_stb` is 1 during the core clock that comes D clocks after SCL went high, counting the first high clock as 0. It is never 1 during the first high phase after `enable` rises, because that phase did not begin with a rising edge.
- R7: A delay greater than or equal to H is treated as H-1, so its strobe lands in the last core clock of the phase.
- R8: Each strobe is a single-cycle pulse. It is suppressed in the same cycle that `enable` is low.
- R9: If `div_value` changes during a phase, the phase ends at the first enabled edge at which the elapsed count is at least the new H-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high; SCL rests high when low |
| div_value | input | 16 | SCL period in core clocks; bit 0 is ignored |
| delay_word | input | 32 | [31:16] drive delay after the falling edge, [15:0] sample delay after the rising edge |
| scl_out | output | 1 | SCL level |
| drive_stb | output | 1 | One-cycle pulse: drive the next SDA bit now |
| sample_stb | output | 1 | One-cycle pulse: sample SDA now |

## Verification
Two functions can land in the same core clock: a strobe placed at the last count of a phase, and the SCL edge that ends that phase. This happens for every delay clamped by R7, and when H is 1 it happens on every clock. The bench drives oversized delays and divider values of 0, 1 and 2, then compares each cycle against a behavioural model. That comparison shows the strobe appears before the level flips and never after it. A second collision is `enable` falling in the very cycle a strobe is due. The bench sweeps the disable point across a whole SCL period and expects the strobe to vanish in that cycle while SCL returns high one edge later.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  // Level of SCL during which a given strobe may fire.
  typedef enum logic {
    SCL_LOW  = 1'b0,
    SCL_HIGH = 1'b1
  } scl_level_e;

endpackage

// File: rtl/i2c_scl_cfg.sv
// Decodes the divider into a phase terminal count and clamps both delays.
module i2c_scl_cfg #(
  parameter int DIV_W = 16,
  parameter int DLY_W = 16,
  parameter int HW    = DIV_W - 1
) (
  input  logic [DIV_W-1:0]   div_value,
  input  logic [2*DLY_W-1:0] delay_word,
  output logic [HW-1:0]      term_cnt,
  output logic [1:0][HW-1:0] dly_lim   // [1] drive (falling), [0] sample (rising)
);

  logic [HW-1:0] half_len;

  // Dropping bit 0 makes the period even; zero collapses to one clock per phase.
  always_comb begin
    half_len = HW'(div_value >> 1);
    if (half_len == '0) half_len = HW'(1);
    term_cnt = half_len - HW'(1);
  end

  localparam int CW = (DLY_W > HW) ? DLY_W : HW;

  for (genvar g = 0; g < 2; g++) begin : g_clamp
    logic [DLY_W-1:0] raw;
    logic [CW-1:0]    raw_w;
    logic [CW-1:0]    term_w;
    assign raw     = delay_word[g*DLY_W +: DLY_W];
    assign raw_w   = CW'(raw);
    assign term_w  = CW'(term_cnt);
    assign dly_lim[g] = (raw_w > term_w) ? term_cnt : raw_w[HW-1:0];
  end

endmodule

// File: rtl/i2c_scl_phase.sv
// Phase counter and SCL level register.
module i2c_scl_phase #(
  parameter int HW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [HW-1:0] term_cnt,
  output logic          scl,
  output logic [HW-1:0] cnt,
  output logic          seen_fall
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl       <= 1'b1;
      cnt       <= '0;
      seen_fall <= 1'b0;
    end else if (!enable) begin
      scl       <= 1'b1;
      cnt       <= '0;
      seen_fall <= 1'b0;
    end else if (cnt >= term_cnt) begin
      cnt <= '0;
      scl <= ~scl;
      if (scl) seen_fall <= 1'b1;
    end else begin
      cnt <= cnt + HW'(1);
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl && cnt == '0));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt < term_cnt) |=> (scl == $past(scl)));

  // R9
  phase_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt >= term_cnt) |=> (cnt == '0 && scl != $past(scl)));

endmodule

// File: rtl/i2c_scl_strobe.sv
// One edge-delay strobe: fires when the phase count reaches the clamped delay.
module i2c_scl_strobe #(
  parameter int                      HW    = 15,
  parameter i2c_scl_pkg::scl_level_e LEVEL = i2c_scl_pkg::SCL_LOW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          scl,
  input  logic          armed,
  input  logic [HW-1:0] cnt,
  input  logic [HW-1:0] lim,
  output logic          stb
);

  assign stb = enable && armed && (scl == logic'(LEVEL)) && (cnt == lim);

  // R5 / R6
  level_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (scl == logic'(LEVEL)));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R8
  gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !stb);

endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing #(
  parameter int DIV_W = 16,
  parameter int DLY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [DIV_W-1:0]   div_value,
  input  logic [2*DLY_W-1:0] delay_word,
  output logic               scl_out,
  output logic               drive_stb,
  output logic               sample_stb
);

  import i2c_scl_pkg::*;

  localparam int HW = DIV_W - 1;

  logic [HW-1:0]      term_cnt;
  logic [1:0][HW-1:0] dly_lim;
  logic [HW-1:0]      cnt;
  logic               scl;
  logic               seen_fall;

  i2c_scl_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W), .HW(HW)) u_cfg (
    .div_value  (div_value),
    .delay_word (delay_word),
    .term_cnt   (term_cnt),
    .dly_lim    (dly_lim)
  );

  i2c_scl_phase #(.HW(HW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .term_cnt  (term_cnt),
    .scl       (scl),
    .cnt       (cnt),
    .seen_fall (seen_fall)
  );

  i2c_scl_strobe #(.HW(HW), .LEVEL(SCL_LOW)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .scl    (scl),
    .armed  (1'b1),
    .cnt    (cnt),
    .lim    (dly_lim[1]),
    .stb    (drive_stb)
  );

  i2c_scl_strobe #(.HW(HW), .LEVEL(SCL_HIGH)) u_sample (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .scl    (scl),
    .armed  (seen_fall),
    .cnt    (cnt),
    .lim    (dly_lim[0]),
    .stb    (sample_stb)
  );

  assign scl_out = scl;

  // R5 / R6: the two strobes never coincide
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_stb && sample_stb));

endmodule

// File: tb/tb_i2c_scl_timing.sv
`timescale 1ns/1ps
module tb_i2c_scl_timing;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [15:0] div_value;
  logic [31:0] delay_word;
  logic        scl_out, drive_stb, sample_stb;

  always #2.5 clk = ~clk;

  i2c_scl_timing dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_value(div_value),
    .delay_word(delay_word), .scl_out(scl_out), .drive_stb(drive_stb),
    .sample_stb(sample_stb)
  );

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_scl = 1;
  int m_ticks = 0;
  int m_seen = 0;

  function automatic int phase_len();
    int h = int'(div_value) / 2;
    return (h < 1) ? 1 : h;
  endfunction

  function automatic int clamp_dly(int d);
    return (d > phase_len() - 1) ? phase_len() - 1 : d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      m_scl = 1; m_ticks = 0; m_seen = 0;
    end else if (m_ticks + 1 >= phase_len()) begin
      if (m_scl == 1) m_seen = 1;
      m_scl = 1 - m_scl;
      m_ticks = 0;
    end else begin
      m_ticks = m_ticks + 1;
    end
  end

  always @(negedge clk) begin
    int exp_drv, exp_smp;
    if (!rst_n) begin
      m_scl = 1; m_ticks = 0; m_seen = 0;
    end
    exp_drv = (rst_n && enable && m_scl == 0 &&
               m_ticks == clamp_dly(int'(delay_word[31:16]))) ? 1 : 0;
    exp_smp = (rst_n && enable && m_scl == 1 && m_seen == 1 &&
               m_ticks == clamp_dly(int'(delay_word[15:0]))) ? 1 : 0;
    vectors++;
    if (int'(scl_out) != m_scl) begin
      miscompares++;
      $display("FAIL %s scl_out got %0b exp %0d at %0t", cur_req, scl_out, m_scl, $time);
    end
    if (int'(drive_stb) != exp_drv) begin
      miscompares++;
      $display("FAIL %s drive_stb got %0b exp %0d at %0t", cur_req, drive_stb, exp_drv, $time);
    end
    if (int'(sample_stb) != exp_smp) begin
      miscompares++;
      $display("FAIL %s sample_stb got %0b exp %0d at %0t", cur_req, sample_stb, exp_smp, $time);
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; div_value = 16'd10; delay_word = 32'h0002_0003;
    cur_req = "R1"; run(4);
    rst_n = 1'b1; run(5);

    cur_req = "R2"; enable = 1'b1; run(60);

    cur_req = "R5"; enable = 1'b0; run(1);
    div_value = 16'd12; delay_word = {16'd4, 16'd0}; enable = 1'b1; run(50);

    cur_req = "R6"; enable = 1'b0; run(2);
    delay_word = {16'd0, 16'd5}; enable = 1'b1; run(50);

    cur_req = "R3"; enable = 1'b0; run(1);
    div_value = 16'd11; delay_word = {16'd1, 16'd2}; enable = 1'b1; run(50);

    cur_req = "R4"; div_value = 16'd0; delay_word = 32'h0000_0000; run(20);
    div_value = 16'd1; delay_word = {16'd3, 16'd3}; run(20);
    div_value = 16'd2; delay_word = 32'h0000_0000; run(20);

    cur_req = "R7"; enable = 1'b0; run(1);
    div_value = 16'd8; delay_word = {16'hFFFF, 16'd4}; enable = 1'b1; run(40);

    cur_req = "R8"; div_value = 16'd6; delay_word = {16'd2, 16'd1};
    for (int k = 0; k < 10; k++) begin
      enable = 1'b1; run(7 + k);
      enable = 1'b0; run(2);
    end
    delay_word = 32'h0000_0000;
    for (int k = 0; k < 8; k++) begin
      enable = 1'b1; run(4 + k);
      enable = 1'b0; run(1);
    end

    cur_req = "R9"; div_value = 16'd40; delay_word = {16'd5, 16'd6}; enable = 1'b1; run(15);
    div_value = 16'd8; run(30);
    div_value = 16'd30; run(8);
    div_value = 16'd4; run(20);

    cur_req = "R7"; div_value = 16'hFFFE; delay_word = {16'h4000, 16'hFFFF}; run(100);

    cur_req = "R1"; div_value = 16'd6; run(10);
    rst_n = 1'b0; run(3);
    rst_n = 1'b1; run(20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule